// File: doc/BRIEF.md
# Unaligned Burst Word Mover

This block copies a run of 32-bit words between a small word-addressed local buffer and a shared memory that is addressed in bytes. The starting byte address in shared memory may be any offset, not just a multiple of four. The mover itself absorbs the misalignment. On a fetch it reads two neighbouring memory words and funnel-shifts the pair by the low two address bits. On a store it rotates local data into the right byte lanes and writes each memory word with a 4-bit byte strobe. Software therefore issues exactly one burst command, whatever the alignment.

A transfer is a two-command sequence. First, a set-count command loads the burst length, with `count+1` words to move. Then a fetch or store command supplies the byte address and the local starting word. A second form of set-count arms a transparent store. In that mode, any source byte equal to 0xFF is not written, so the destination byte keeps its old value. The count and the transparent flag serve only the next transfer command and are cleared when it starts.

The shared memory port is single-ported, with one access per cycle and a read latency of one cycle. The local buffer port is read combinationally and written on the clock edge.

Top module: `burst_lane_mover`

## Requirements
- R1: While reset is held and directly after it, `busy`, `done`, `mem_en` and `loc_we` are all 0.
- R2: A fetch (`cmd_op`=2'b10) from byte address A with count c writes local words L..L+c. Local word L+k equals shared bytes A+4k (bits 7:0) up to A+4k+3 (bits 31:24), for every A mod 4.
- R3: A store (`cmd_op`=2'b11) to byte address A with count c writes shared bytes A..A+4(c+1)-1 from local words L..L+c in the same little-endian order, for every A mod 4. Byte A-1 and byte A+4(c+1) are unchanged.
- R4: A transfer moves exactly count+1 words, so a count of 0 moves one word. Local word L+c+1 is untouched by a fetch.
- R5: A transfer command clears the loaded count and the transparent flag. A later transfer with no new set-count moves one word, and stores it opaquely.
- R6: After a transparent set-count (`cmd_op`=2'b01), the next store leaves every destination byte whose source byte is 0xFF unchanged. It writes all other bytes normally.
- R7: `busy` rises on the edge that accepts a transfer command. When `busy` falls, `done` is 1 for exactly that one cycle.
- R8: Commands presented while `busy` is 1 are ignored, including a set-count.
- R9: A store keeps `busy` high for count+2 cycles, which are its memory accesses. A fetch keeps it high for count+3 cycles: count+2 reads plus one cycle to capture the last word. `mem_en` is 1 only while `busy` is 1.
- R10: A command presented in the same cycle as `done` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present; taken when `busy` is 0 |
| cmd_op | input | 2 | 00 set-count, 01 set-count transparent, 10 fetch, 11 store |
| cmd_data | input | AW | Count (low CW bits) or shared byte address |
| cmd_loc | input | LAW | Local starting word for fetch/store |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_en | output | 1 | Shared memory access this cycle |
| mem_be | output | 4 | Byte write strobes; 0 means read |
| mem_addr | output | AW-2 | Shared memory word address |
| mem_wdata | output | 32 | Shared memory write data |
| mem_rdata | input | 32 | Shared memory read data, one cycle after a read |
| loc_addr | output | LAW | Local buffer word address |
| loc_we | output | 1 | Local buffer write enable |
| loc_wdata | output | 32 | Local buffer write data |
| loc_rdata | input | 32 | Local buffer read data (combinational) |

## Verification
A transfer's completion pulse and the acceptance of the following command can fall in the same cycle. This is because `busy` is already low while `done` is high. The bench provokes this overlap on purpose: its transfer task returns in the `done` cycle, and the next set-count is driven immediately. The bench then judges the overlap by the data. The following burst must move exactly the newly loaded number of words, and the bench checks the local word just past the burst as unchanged.

// File: rtl/mover_pkg.sv
package mover_pkg;

  localparam int LANES = 4;

  typedef enum logic [1:0] {
    OP_COUNT        = 2'b00,
    OP_COUNT_SKIPFF = 2'b01,
    OP_FETCH        = 2'b10,
    OP_STORE        = 2'b11
  } op_e;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_DRAIN} st_e;

  // Fetch path: pick the 4 bytes starting at lane sh of {hi_w, lo_w}
  function automatic logic [31:0] align_fetch(input logic [31:0] lo_w,
                                              input logic [31:0] hi_w,
                                              input logic [1:0]  sh);
    logic [63:0] cat;
    cat = {hi_w, lo_w} >> {sh, 3'b000};
    return cat[31:0];
  endfunction

  // Store path: lane l of the result is source byte (4 + l - sh) of {hi_w, lo_w}
  function automatic logic [31:0] align_store(input logic [31:0] lo_w,
                                              input logic [31:0] hi_w,
                                              input logic [1:0]  sh);
    logic [63:0] cat;
    cat = {hi_w, lo_w} >> (7'd32 - 7'({sh, 3'b000}));
    return cat[31:0];
  endfunction

  // Lanes that belong to the burst on the first, last or a middle memory word
  function automatic logic [LANES-1:0] edge_mask(input logic [1:0] sh,
                                                 input logic head,
                                                 input logic tail);
    logic [LANES-1:0] m;
    for (int l = 0; l < LANES; l++)
      m[l] = head ? (l >= int'(sh)) : (tail ? (l < int'(sh)) : 1'b1);
    return m;
  endfunction

endpackage

// File: rtl/mover_cmd.sv
module mover_cmd
  import mover_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [CW-1:0] cmd_cnt,
  input  logic          busy,
  output logic          start,
  output logic          start_store,
  output logic [CW-1:0] cnt,
  output logic          skipff
);

  logic accept;
  assign accept      = cmd_valid && !busy;
  assign start       = accept && cmd_op[1];
  assign start_store = accept && (cmd_op == OP_STORE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      skipff <= 1'b0;
    end else if (start) begin
      cnt    <= '0;
      skipff <= 1'b0;
    end else if (accept) begin
      cnt    <= cmd_cnt;
      skipff <= (cmd_op == OP_COUNT_SKIPFF);
    end
  end

  // R5
  count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == '0 && !skipff));

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(cnt) && $stable(skipff)));

endmodule

// File: rtl/mover_seq.sv
module mover_seq
  import mover_pkg::*;
#(
  parameter int CW  = 6,
  parameter int AW  = 12,
  parameter int LAW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           start_store,
  input  logic           skip_in,
  input  logic [CW-1:0]  cnt_in,
  input  logic [AW-1:0]  addr_in,
  input  logic [LAW-1:0] loc_in,
  output logic           busy,
  output logic           done,
  output logic           issue,
  output logic           store,
  output logic           skip,
  output logic           head,
  output logic           tail,
  output logic [1:0]     off,
  output logic [AW-3:0]  mem_word,
  output logic [LAW-1:0] loc_word,
  output logic           cap_v,
  output logic           cap_we
);

  localparam int IW  = CW + 1;
  localparam int WAW = AW - 2;

  st_e            st;
  logic [IW-1:0]  idx, cap_idx;
  logic [CW-1:0]  cnt_l;
  logic [WAW-1:0] wbase;
  logic [LAW-1:0] lbase;
  logic           last;

  assign last  = (idx == ({1'b0, cnt_l} + IW'(1)));
  assign busy  = (st != ST_IDLE);
  assign issue = (st == ST_ISSUE);
  assign head  = (idx == '0);
  assign tail  = last;

  assign mem_word = wbase + WAW'(idx);
  assign loc_word = store ? (lbase + LAW'(idx)) : (lbase + LAW'(cap_idx - IW'(1)));
  assign cap_we   = cap_v && (cap_idx != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      idx     <= '0;
      cap_idx <= '0;
      cap_v   <= 1'b0;
      cnt_l   <= '0;
      wbase   <= '0;
      lbase   <= '0;
      off     <= '0;
      store   <= 1'b0;
      skip    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done    <= 1'b0;
      cap_v   <= issue && !store;
      cap_idx <= idx;
      case (st)
        ST_IDLE: if (start) begin
          st    <= ST_ISSUE;
          idx   <= '0;
          cnt_l <= cnt_in;
          wbase <= addr_in[AW-1:2];
          off   <= addr_in[1:0];
          lbase <= loc_in;
          store <= start_store;
          skip  <= skip_in;
        end
        ST_ISSUE: begin
          idx <= idx + IW'(1);
          if (last) begin
            if (store) begin
              st   <= ST_IDLE;
              done <= 1'b1;
            end else begin
              st <= ST_DRAIN;
            end
          end
        end
        default: begin
          st   <= ST_IDLE;
          done <= 1'b1;
        end
      endcase
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

endmodule

// File: rtl/mover_lane.sv
module mover_lane
  import mover_pkg::*;
(
  input  logic [1:0]       off,
  input  logic             head,
  input  logic             tail,
  input  logic             skip,
  input  logic             store,
  input  logic             issue,
  input  logic [31:0]      prev,
  input  logic [31:0]      loc_cur,
  input  logic [31:0]      mem_cur,
  output logic [31:0]      store_word,
  output logic [LANES-1:0] store_be,
  output logic [31:0]      fetch_word
);

  logic [LANES-1:0] span;

  assign store_word = align_store(prev, loc_cur, off);
  assign fetch_word = align_fetch(prev, mem_cur, off);
  assign span       = edge_mask(off, head, tail);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic opaque;
    assign opaque      = !(skip && (store_word[8*g +: 8] == 8'hFF));
    assign store_be[g] = issue && store && span[g] && opaque;
  end

endmodule

// File: rtl/burst_lane_mover.sv
module burst_lane_mover
  import mover_pkg::*;
#(
  parameter int CW  = 6,
  parameter int AW  = 12,
  parameter int LAW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  input  logic [1:0]     cmd_op,
  input  logic [AW-1:0]  cmd_data,
  input  logic [LAW-1:0] cmd_loc,
  output logic           busy,
  output logic           done,
  output logic           mem_en,
  output logic [3:0]     mem_be,
  output logic [AW-3:0]  mem_addr,
  output logic [31:0]    mem_wdata,
  input  logic [31:0]    mem_rdata,
  output logic [LAW-1:0] loc_addr,
  output logic           loc_we,
  output logic [31:0]    loc_wdata,
  input  logic [31:0]    loc_rdata
);

  logic          start, start_store, skipff, skip, store, issue;
  logic          head, tail, cap_v, cap_we;
  logic [CW-1:0] cnt;
  logic [1:0]    off;
  logic [31:0]   prev, store_word, fetch_word;

  mover_cmd #(.CW(CW)) u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_cnt(cmd_data[CW-1:0]), .busy(busy), .start(start),
    .start_store(start_store), .cnt(cnt), .skipff(skipff)
  );

  mover_seq #(.CW(CW), .AW(AW), .LAW(LAW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_store(start_store),
    .skip_in(skipff), .cnt_in(cnt), .addr_in(cmd_data), .loc_in(cmd_loc),
    .busy(busy), .done(done), .issue(issue), .store(store), .skip(skip),
    .head(head), .tail(tail), .off(off), .mem_word(mem_addr),
    .loc_word(loc_addr), .cap_v(cap_v), .cap_we(cap_we)
  );

  mover_lane u_lane (
    .off(off), .head(head), .tail(tail), .skip(skip), .store(store),
    .issue(issue), .prev(prev), .loc_cur(loc_rdata), .mem_cur(mem_rdata),
    .store_word(store_word), .store_be(mem_be), .fetch_word(fetch_word)
  );

  // Previous word of the stream: local word on stores, memory word on fetches
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                prev <= '0;
    else if (issue && store)   prev <= loc_rdata;
    else if (cap_v)            prev <= mem_rdata;
  end

  assign mem_en    = issue;
  assign mem_wdata = store_word;
  assign loc_we    = cap_we;
  assign loc_wdata = fetch_word;

  // R2
  loc_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loc_we |-> busy);

  // R3
  strobe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && (mem_be != '0)) |-> busy);

  // R9
  access_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> busy);

endmodule

// File: tb/burst_lane_mover_test.sv
module burst_lane_mover_test;
  import mover_pkg::*;

  localparam int CW = 6, AW = 12, LAW = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cmd_valid = 1'b0;
  logic [1:0]     cmd_op = 2'b00;
  logic [AW-1:0]  cmd_data = '0;
  logic [LAW-1:0] cmd_loc = '0;
  logic           busy, done, mem_en, loc_we;
  logic [3:0]     mem_be;
  logic [AW-3:0]  mem_addr;
  logic [31:0]    mem_wdata, mem_rdata, loc_wdata, loc_rdata;
  logic [LAW-1:0] loc_addr;

  always #5 clk = ~clk;

  burst_lane_mover #(.CW(CW), .AW(AW), .LAW(LAW)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_loc(cmd_loc), .busy(busy), .done(done),
    .mem_en(mem_en), .mem_be(mem_be), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .loc_addr(loc_addr),
    .loc_we(loc_we), .loc_wdata(loc_wdata), .loc_rdata(loc_rdata)
  );

  // Memories around the block
  logic [31:0] shmem [64];
  logic [31:0] locm  [64];
  logic [7:0]  refb  [256];

  always @(posedge clk) begin
    if (mem_en) begin
      mem_rdata <= shmem[mem_addr[5:0]];
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) shmem[mem_addr[5:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
    end
    if (loc_we) locm[loc_addr] <= loc_wdata;
  end
  assign loc_rdata = locm[loc_addr];

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  function automatic void chk(int req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endfunction

  // Scoreboard
  typedef struct {
    bit          is_loc;
    int          addr;
    logic [31:0] exp;
    int          req;
  } item_t;
  item_t sb[$];

  always @(negedge clk) begin
    if (done) begin
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        if (it.is_loc) act = locm[it.addr];
        else act = {24'h0, shmem[it.addr / 4][8*(it.addr % 4) +: 8]};
        chk(it.req, act, it.exp, it.is_loc ? "local word" : "shared byte");
      end
    end
  end

  task automatic send(logic [1:0] op, int data, int loc);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_data  = AW'(data);
    cmd_loc   = LAW'(loc);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // One transfer; returns at the negedge where done is seen
  task automatic xfer(bit st, int addr, int lb, int n, bit skp, int req, bit intrude);
    int cyc;
    item_t it;
    send(st ? OP_STORE : OP_FETCH, addr, lb);
    if (st) begin
      for (int k = 0; k < n; k++)
        for (int b = 0; b < 4; b++) begin
          logic [7:0] sbyte;
          sbyte = locm[lb + k][8*b +: 8];
          if (!(skp && sbyte == 8'hFF)) refb[addr + 4*k + b] = sbyte;
        end
      for (int a = addr - 1; a <= addr + 4*n; a++)
        if (a >= 0 && a < 256) begin
          it = '{1'b0, a, {24'h0, refb[a]}, req};
          sb.push_back(it);
        end
    end else begin
      for (int k = 0; k < n; k++) begin
        int a;
        a = addr + 4*k;
        it = '{1'b1, lb + k, {refb[a+3], refb[a+2], refb[a+1], refb[a]}, req};
        sb.push_back(it);
      end
      // R4: the word after the burst stays as it was
      if (lb + n < 64) begin
        it = '{1'b1, lb + n, locm[lb + n], 4};
        sb.push_back(it);
      end
    end
    cyc = 0;
    while (busy) begin
      if (intrude && cyc == 0) begin
        cmd_valid = 1'b1; cmd_op = OP_COUNT; cmd_data = AW'(7);
      end
      cyc++;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    // R9: busy length
    chk(9, cyc, st ? n + 1 : n + 2, "busy cycles");
    // R7: done coincides with busy falling
    chk(7, {31'h0, done}, 32'h1, "done at busy fall");
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      shmem[i] = 32'h9E3779B9 * (i + 1);
      locm[i]  = 32'h10203040 + 32'h01010101 * i;
      for (int b = 0; b < 4; b++) refb[4*i + b] = shmem[i][8*b +: 8];
    end
    locm[5] = 32'hFF12FF34;
    locm[6] = 32'h56FFFFFF;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(1, {28'h0, busy, done, mem_en, loc_we}, 32'h0, "outputs in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(1, {28'h0, busy, done, mem_en, loc_we}, 32'h0, "outputs after reset");

    // R3: stores at every byte offset, three words each
    for (int o = 0; o < 4; o++) begin
      send(OP_COUNT, 2, 0);
      xfer(1'b1, 16 * (o + 1) + o, o, 3, 1'b0, 3, 1'b0);
    end

    // R2: fetches at every byte offset, four words each
    for (int o = 0; o < 4; o++) begin
      send(OP_COUNT, 3, 0);
      xfer(1'b0, 120 + 21 * o, 20 + 6 * o, 4, 1'b0, 2, 1'b0);
    end

    // R6: transparent store skips 0xFF source bytes
    send(OP_COUNT_SKIPFF, 1, 0);
    xfer(1'b1, 205, 5, 2, 1'b1, 6, 1'b0);

    // R5: no new set-count -> one word, opaque (0xFF bytes written)
    xfer(1'b1, 214, 6, 1, 1'b0, 5, 1'b0);

    // R4: count zero at offset 3 moves one word
    send(OP_COUNT, 0, 0);
    xfer(1'b1, 223, 7, 1, 1'b0, 4, 1'b0);

    // R8: set-count offered while busy is ignored
    send(OP_COUNT, 1, 0);
    xfer(1'b0, 230, 50, 2, 1'b0, 8, 1'b1);
    xfer(1'b0, 240, 55, 1, 1'b0, 8, 1'b0);

    // R10: set-count driven in the done cycle is taken
    send(OP_COUNT, 2, 0);
    xfer(1'b0, 243, 58, 3, 1'b0, 10, 1'b0);

    @(negedge clk);
    // R7: done lasts one cycle
    chk(7, {31'h0, done}, 32'h0, "done after one cycle");
    chk(9, {31'h0, mem_en}, 32'h0, "no access when idle");
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule